// File: doc/BRIEF.md
# Page Program Sequencer with Write Protection

This block sits between a serial-bus protocol engine and a byte-wide nonvolatile array. The engine gathers a write command into a page buffer of up to sixteen bytes. When the STOP that ends the command arrives, the engine issues a single-cycle commit. The sequencer then captures the start address, the byte count and the buffer contents. It holds busy for a programming interval that is set by a parameter, and then issues the buffered bytes to the array write port, one byte per clock. The byte addresses wrap inside the 16-byte page.

Write protection follows a window. From the START of a command up to the strobe that marks the clock edge capturing the first data byte's last bit, the protect input has no effect. From that strobe until the commit, protect cancels the pending command. While a cycle is running, protect stops it at once: busy falls on the next clock, and the start location receives a fixed marker byte to stand for its undefined contents. A low-supply indication rejects new commits and suppresses array writes while it is active.

Top module: `ews_top`

## Requirements
- R1: A commit in the idle state starts a cycle when all of these hold: the byte count is 1 to 16, protect is low, low-supply is low, and no cancel has been latched. Busy is high in the cycle after the commit.
- R2: Busy stays high for exactly PROG_CYCLES + count cycles after the commit and is low in the next cycle. Array writes occur only in the last count of those cycles.
- R3: A protect pulse that occurs after the START and before the first-data strobe has no effect. The cycle proceeds normally.
- R4: If protect is high in the strobe cycle, or in any later cycle before the commit, the command is cancelled. Busy stays low and no array write occurs.
- R5: If protect is high during any busy cycle, busy is low in the next cycle. In that cycle exactly one array write puts the marker value 0xE7 at the captured start address. The block is idle in the cycle after that.
- R6: If protect is high in the commit cycle, the commit is rejected, whatever the address.
- R7: If low-supply is high in the commit cycle, the commit is rejected. While low-supply is high during a running cycle, no array write is issued, and busy timing is unchanged.
- R8: Byte i of the buffer, held in page bits [8i+7:8i], is written in order of ascending i. It goes to the address whose upper six bits equal the start address's upper six bits and whose lower four bits are (start low four bits + i) mod 16.
- R9: A commit that arrives while busy is ignored. Addresses, data and timing stay those of the running cycle.
- R10: After reset, busy and the write enable are low.
- R11: A commit with a byte count of zero is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_start_i | input | 1 | Pulse at the START of a command; reopens the don't-care period for protect |
| d0_strobe_i | input | 1 | Pulse at the clock edge that captured the first data byte's last bit |
| commit_i | input | 1 | Pulse at the STOP ending a write command |
| start_addr_i | input | ADDR_W | Start byte address of the command |
| byte_count_i | input | CNT_W | Number of buffered bytes (1 to PAGE_BYTES) |
| page_data_i | input | PAGE_BYTES*DATA_W | Page buffer; byte i occupies bits [8i+7:8i] |
| wp_i | input | 1 | Write protect |
| low_supply_i | input | 1 | Low-supply write inhibit |
| busy_o | output | 1 | Programming cycle in progress |
| mem_we_o | output | 1 | Array write enable |
| mem_addr_o | output | ADDR_W | Array write address |
| mem_wdata_o | output | DATA_W | Array write data |

## Verification
Take the rising edge that samples a commit as cycle 0. Busy is due in cycle 1. Byte i is due in cycle PROG_CYCLES + 1 + i, and busy must be low in cycle PROG_CYCLES + count + 1. After protect is sampled high in a busy cycle, the marker write and the low busy are both due exactly one cycle later. The bench counts cycles from the commit and compares busy, enable, address and data in every one of those cycles, sampling at the falling edge after each rising edge. It uses a short programming interval and sweeps every byte count, including page-wrapping start addresses.

// File: rtl/ews_pkg.sv
package ews_pkg;

    localparam int EWS_ADDR_W     = 10;
    localparam int EWS_DATA_W     = 8;
    localparam int EWS_PAGE_BYTES = 16;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PROG  = 2'd1,
        ST_WRITE = 2'd2,
        ST_ABORT = 2'd3
    } ews_state_e;

    typedef struct packed {
        logic is_write;
        logic is_abort;
    } ews_port_sel_t;

    function automatic ews_port_sel_t port_select(ews_state_e st);
        ews_port_sel_t sel;
        sel.is_write = (st == ST_WRITE);
        sel.is_abort = (st == ST_ABORT);
        return sel;
    endfunction

endpackage

// File: rtl/ews_cancel_window.sv
module ews_cancel_window (
    input  logic clk,
    input  logic rst,
    input  logic cmd_start_i,
    input  logic d0_strobe_i,
    input  logic commit_i,
    input  logic wp_i,
    output logic cancel_o
);

    logic armed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q  <= 1'b0;
            cancel_o <= 1'b0;
        end else if (cmd_start_i || commit_i) begin
            armed_q  <= 1'b0;
            cancel_o <= 1'b0;
        end else begin
            armed_q  <= armed_q | d0_strobe_i;
            cancel_o <= cancel_o | (wp_i & (armed_q | d0_strobe_i));
        end
    end

    // R3: a new START always clears a latched cancel
    p_start_clears_r3: assert property (@(posedge clk) disable iff (rst)
        cmd_start_i |=> !cancel_o);

    // R4: protect inside the open window latches a cancel
    p_window_latch_r4: assert property (@(posedge clk) disable iff (rst)
        (armed_q && wp_i && !cmd_start_i && !commit_i) |=> cancel_o);

endmodule

// File: rtl/ews_prog_timer.sv
module ews_prog_timer #(
    parameter int PROG_CYCLES = 500000
) (
    input  logic clk,
    input  logic rst,
    input  logic load_i,
    output logic expired_o
);

    localparam int CYC_W = $clog2(PROG_CYCLES + 1);
    localparam logic [CYC_W-1:0] LOAD_VAL = CYC_W'(PROG_CYCLES - 1);

    logic [CYC_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= LOAD_VAL;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired_o = (cnt_q == '0);

    // R2: the interval counter never leaves its loaded range
    p_timer_bound_r2: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LOAD_VAL);

endmodule

// File: rtl/ews_top.sv
module ews_top
    import ews_pkg::*;
#(
    parameter int          ADDR_W      = EWS_ADDR_W,
    parameter int          DATA_W      = EWS_DATA_W,
    parameter int          PAGE_BYTES  = EWS_PAGE_BYTES,
    parameter int          PROG_CYCLES = 500000,
    parameter logic [7:0]  MARK_BYTE   = 8'hE7,
    localparam int         CNT_W       = $clog2(PAGE_BYTES + 1),
    localparam int         OFS_W       = $clog2(PAGE_BYTES)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         cmd_start_i,
    input  logic                         d0_strobe_i,
    input  logic                         commit_i,
    input  logic [ADDR_W-1:0]            start_addr_i,
    input  logic [CNT_W-1:0]             byte_count_i,
    input  logic [PAGE_BYTES*DATA_W-1:0] page_data_i,
    input  logic                         wp_i,
    input  logic                         low_supply_i,
    output logic                         busy_o,
    output logic                         mem_we_o,
    output logic [ADDR_W-1:0]            mem_addr_o,
    output logic [DATA_W-1:0]            mem_wdata_o
);

    localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(PAGE_BYTES);

    ews_state_e                    state_q;
    logic [ADDR_W-1:0]             cap_addr_q;
    logic [CNT_W-1:0]              cap_cnt_q;
    logic [PAGE_BYTES*DATA_W-1:0]  cap_data_q;
    logic [CNT_W-1:0]              idx_q;
    logic                          cancel_w;
    logic                          expired_w;
    logic                          accept_w;
    ews_port_sel_t                 sel_w;
    logic [DATA_W-1:0]             slot_w [PAGE_BYTES];
    logic [OFS_W-1:0]              ofs_w;

    ews_cancel_window u_window (
        .clk         (clk),
        .rst         (rst),
        .cmd_start_i (cmd_start_i),
        .d0_strobe_i (d0_strobe_i),
        .commit_i    (commit_i),
        .wp_i        (wp_i),
        .cancel_o    (cancel_w)
    );

    ews_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .load_i    (accept_w),
        .expired_o (expired_w)
    );

    assign accept_w = (state_q == ST_IDLE) && commit_i && !cancel_w && !wp_i
                      && !low_supply_i && (byte_count_i != '0)
                      && (byte_count_i <= MAX_CNT);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            cap_addr_q <= '0;
            cap_cnt_q  <= '0;
            cap_data_q <= '0;
            idx_q      <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (accept_w) begin
                        state_q    <= ST_PROG;
                        cap_addr_q <= start_addr_i;
                        cap_cnt_q  <= byte_count_i;
                        cap_data_q <= page_data_i;
                    end
                end
                ST_PROG: begin
                    if (wp_i) begin
                        state_q <= ST_ABORT;
                    end else if (expired_w) begin
                        state_q <= ST_WRITE;
                        idx_q   <= '0;
                    end
                end
                ST_WRITE: begin
                    if (wp_i) begin
                        state_q <= ST_ABORT;
                    end else if (idx_q == cap_cnt_q - 1'b1) begin
                        state_q <= ST_IDLE;
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
        assign slot_w[g] = cap_data_q[g*DATA_W +: DATA_W];
    end

    assign sel_w = port_select(state_q);
    assign ofs_w = cap_addr_q[OFS_W-1:0] + idx_q[OFS_W-1:0];

    always_comb begin
        busy_o      = (state_q == ST_PROG) || sel_w.is_write;
        mem_we_o    = (sel_w.is_write || sel_w.is_abort) && !low_supply_i;
        mem_addr_o  = cap_addr_q;
        mem_wdata_o = DATA_W'(MARK_BYTE);
        if (sel_w.is_write) begin
            mem_addr_o  = {cap_addr_q[ADDR_W-1:OFS_W], ofs_w};
            mem_wdata_o = slot_w[idx_q[OFS_W-1:0]];
        end
    end

    // R1: busy only ever starts from a commit
    p_start_on_commit_r1: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> $past(commit_i));

    // R5: protect during a running cycle drops busy on the next clock
    p_abort_drop_r5: assert property (@(posedge clk) disable iff (rst)
        (busy_o && wp_i) |=> !busy_o);

    // R6: protect at commit never starts a cycle
    p_wp_blocks_r6: assert property (@(posedge clk) disable iff (rst)
        (wp_i && commit_i && !busy_o) |=> !busy_o);

    // R7: low supply at commit never starts a cycle
    p_lowsup_blocks_r7: assert property (@(posedge clk) disable iff (rst)
        (low_supply_i && commit_i) |=> !$rose(busy_o));

    // R8: consecutive byte writes stay inside one page
    p_same_page_r8: assert property (@(posedge clk) disable iff (rst)
        (sel_w.is_write && idx_q != '0)
        |-> mem_addr_o[ADDR_W-1:OFS_W] == $past(mem_addr_o[ADDR_W-1:OFS_W]));

    // R9: a commit while busy leaves the captured command untouched
    p_busy_ignore_r9: assert property (@(posedge clk) disable iff (rst)
        (busy_o && commit_i) |=> ($stable(cap_addr_q) && $stable(cap_cnt_q)));

endmodule

// File: tb/ews_top_tb_top.sv
module ews_top_tb_top;

    localparam int P      = 12;
    localparam int NB     = 16;
    localparam int AW     = 10;
    localparam int CW     = 5;
    localparam int MARK   = 8'hE7;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cmd_start = 1'b0;
    logic              d0_strobe = 1'b0;
    logic              commit = 1'b0;
    logic [AW-1:0]     start_addr = '0;
    logic [CW-1:0]     byte_count = '0;
    logic [NB*8-1:0]   page_data = '0;
    logic              wp = 1'b0;
    logic              low_supply = 1'b0;
    logic              busy;
    logic              mem_we;
    logic [AW-1:0]     mem_addr;
    logic [7:0]        mem_wdata;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    ews_top #(.PROG_CYCLES(P)) dut_i (
        .clk          (clk),
        .rst          (rst),
        .cmd_start_i  (cmd_start),
        .d0_strobe_i  (d0_strobe),
        .commit_i     (commit),
        .start_addr_i (start_addr),
        .byte_count_i (byte_count),
        .page_data_i  (page_data),
        .wp_i         (wp),
        .low_supply_i (low_supply),
        .busy_o       (busy),
        .mem_we_o     (mem_we),
        .mem_addr_o   (mem_addr),
        .mem_wdata_o  (mem_wdata)
    );

    function automatic int byte_of(int seed, int i);
        return (seed * 29 + i * 53 + 7) & 255;
    endfunction

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // kind: 0 plain, 1 protect before strobe, 2 protect after strobe,
    //       3 protect at commit, 4 low supply at commit, 5 commit while busy
    // a: abort after sample a (0 none); l: low supply from after sample l
    task automatic run_case(string tag, int addr, int n, int kind, int a, int l, int seed);
        bit blocked;
        blocked = (kind >= 2 && kind <= 4) || (n == 0);
        @(negedge clk);
        cmd_start  = 1'b1;
        start_addr = AW'(addr);
        byte_count = CW'(n);
        for (int i = 0; i < NB; i++) page_data[i*8 +: 8] = 8'(byte_of(seed, i));
        if (kind == 1) wp = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
        @(negedge clk);
        wp = 1'b0;
        d0_strobe = 1'b1;
        @(negedge clk);
        d0_strobe = 1'b0;
        if (kind == 2) wp = 1'b1;
        @(negedge clk);
        wp = 1'b0;
        @(negedge clk);
        commit = 1'b1;
        if (kind == 3) wp = 1'b1;
        if (kind == 4) low_supply = 1'b1;
        @(negedge clk);
        commit = 1'b0;
        wp = 1'b0;
        low_supply = 1'b0;
        for (int j = 1; j <= P + n + 3; j++) begin
            int  eb, ew, ea, ed, i;
            bit  ls_on;
            ls_on = (l > 0) && (j > l);
            ea = 0; ed = 0;
            if (blocked) begin
                eb = 0; ew = 0;
            end else if (a > 0 && j == a + 1) begin
                eb = 0; ew = ls_on ? 0 : 1; ea = addr; ed = MARK;
            end else if (a > 0 && j > a + 1) begin
                eb = 0; ew = 0;
            end else begin
                eb = (j <= P + n) ? 1 : 0;
                ew = (j > P && j <= P + n && !ls_on) ? 1 : 0;
                i  = j - P - 1;
                ea = (addr & ~15) | ((addr + i) & 15);
                ed = byte_of(seed, i);
            end
            chk(tag, $sformatf("busy cycle %0d", j), int'(busy), eb);
            chk(tag, $sformatf("we cycle %0d", j), int'(mem_we), ew);
            if (ew == 1 && mem_we) begin
                chk(tag, $sformatf("addr cycle %0d", j), int'(mem_addr), ea);
                chk(tag, $sformatf("data cycle %0d", j), int'(mem_wdata), ed);
            end
            if (a > 0 && j == a) wp = 1'b1;
            if (l > 0 && j == l) low_supply = 1'b1;
            if (kind == 5 && j == 3) begin
                commit = 1'b1;
                start_addr = start_addr ^ 10'h155;
                byte_count = 5'd2;
            end
            if (kind == 5 && j == 4) commit = 1'b0;
            @(negedge clk);
        end
        wp = 1'b0;
        low_supply = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R10", "busy after reset", int'(busy), 0);
        chk("R10", "we after reset", int'(mem_we), 0);

        run_case("R1", 10'h040, 3, 0, 0, 0, 1);
        for (int n = 1; n <= NB; n++) begin
            run_case("R2", (n * 67 + 9) % 1024, n, 0, 0, 0, n + 20);
        end
        run_case("R8", 10'h3FE, 16, 0, 0, 0, 77);
        run_case("R8", 10'h10F, 5, 0, 0, 0, 78);
        run_case("R3", 10'h200, 4, 1, 0, 0, 90);
        run_case("R4", 10'h120, 4, 2, 0, 0, 91);
        run_case("R6", 10'h2A0, 6, 3, 0, 0, 92);
        run_case("R7", 10'h0C3, 6, 4, 0, 0, 93);
        run_case("R7", 10'h0C3, 6, 0, 0, P + 2, 94);
        run_case("R5", 10'h155, 8, 0, 4, 0, 95);
        run_case("R5", 10'h1F9, 8, 0, P + 3, 0, 96);
        run_case("R9", 10'h0A7, 7, 5, 0, 0, 97);
        run_case("R11", 10'h0B0, 0, 0, 0, 0, 98);
        run_case("R1", 10'h3F0, 2, 0, 0, 0, 99);

        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule